// File: doc/BRIEF.md
# Snoop Write-Back Bus Sequencer

This block sequences external bus cycles for a write-back data cache. It runs burst line fills requested by the cache. It also watches an external snoop strobe. When a snoop lands on a line that the cache holds modified, the block raises a pending write-back flag on its hit-modified output. It must then copy that line out to memory before any later read can use the same data.

The difficult case is a back-off request that arrives while a line fill is on the bus. The fill is dropped at once, and no cycle starts while back-off is held. In the cycle after back-off is first seen released, the sequencer opens a four-beat write burst for the snooped line. When the final beat of that write is acknowledged, it reissues the dropped fill from its first beat with the same line address. In that same cycle the hit-modified flag clears. A back-off during the write-back cancels the write as well. The write-back is then replayed in full before the read is retried.

Top module: `sws_wb_seq`

## Requirements
- R1: While reset is high, and after it, addr_strobe_n, last_xfer_n and hit_mod_n are 1, write_nread and fill_done are 0, and bus_beat is 0.
- R2: A sampled snoop (snoop_strobe_n = 0 with snoop_hit_mod = 1) drives hit_mod_n to 0 in the next cycle. A snoop with snoop_hit_mod = 0 leaves hit_mod_n at 1 and starts no bus cycle.
- R3: A fill request opens a read with addr_strobe_n = 0 for exactly one cycle, write_nread = 0 and bus_line equal to the requested line. BEATS data beats follow, each ended by ready_n = 0. bus_beat counts 0 to BEATS-1 and does not move on wait states. fill_done is 1 for one cycle right after the final acknowledged beat.
- R4: last_xfer_n is 0 during the data cycles of beat BEATS-1 only, and it stays 1 in address cycles.
- R5: In the cycle after backoff_n is sampled 0, addr_strobe_n is 1 and the burst in progress is dropped. No cycle starts while backoff_n stays 0.
- R6: With a write-back pending, the cycle after backoff_n is first sampled 1 has addr_strobe_n = 0, write_nread = 1, bus_beat = 0 and bus_line equal to the snooped line.
- R7: The cycle after the final write-back beat is acknowledged has addr_strobe_n = 0, write_nread = 0, bus_beat = 0 and bus_line equal to the aborted fill line. hit_mod_n returns to 1 in that same cycle.
- R8: backoff_n = 0 during any write-back beat cancels it. After release the write-back restarts from beat 0, and the read follows it.
- R9: With no back-off, a snoop that arrives during a fill lets the fill finish. The write strobe then appears in the same cycle as fill_done. A snoop while idle starts the write-back two cycles after the snoop is driven.
- R10: A back-off during a fill with no snoop pending reissues the read from beat 0 with the same line in the cycle after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_req | input | 1 | Request for a line fill, taken when no fill is pending |
| fill_line | input | LINE_W | Line address of the requested fill |
| fill_done | output | 1 | One-cycle pulse when the fill completes |
| snoop_strobe_n | input | 1 | External snoop strobe, active low |
| snoop_hit_mod | input | 1 | Snooped line is held modified |
| snoop_line | input | LINE_W | Line address of the snoop |
| backoff_n | input | 1 | Bus back-off, active low |
| ready_n | input | 1 | Data beat acknowledge, active low |
| addr_strobe_n | output | 1 | Address strobe, active low, one cycle per burst |
| write_nread | output | 1 | 1 for the write-back burst, 0 for a read |
| last_xfer_n | output | 1 | Final-beat marker, active low |
| hit_mod_n | output | 1 | Write-back pending flag, active low |
| bus_line | output | LINE_W | Line address of the current burst |
| bus_beat | output | BEAT_W | Index of the current beat in the burst |

## Verification
The assertions assume that the responder drives ready_n only inside a burst, that every snoop is sampled while hit_mod_n is high, and that back-off is the only way a burst is cut short. The bench keeps to these rules. It issues one snoop per scenario before any write-back is pending. It acknowledges beats only after it has seen the address strobe, and it holds fill_req for one cycle and only when idle. Abort beat, back-off length, wait-state count and the point of a second back-off are swept together, so every replay path is covered under each ready timing.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RADR = 3'd1,
    ST_RDAT = 3'd2,
    ST_WADR = 3'd3,
    ST_WDAT = 3'd4,
    ST_HOLD = 3'd5
  } seq_state_t;
endpackage

// File: rtl/sws_beat_ctr.sv
module sws_beat_ctr #(
  parameter int BEATS = 4,
  localparam int W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         at_last
);
  localparam logic [W-1:0] LAST = W'(BEATS - 1);

  always_comb begin
    if (clr)      cnt_nxt = '0;
    else if (inc) cnt_nxt = cnt + W'(1);
    else          cnt_nxt = cnt;
  end

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/sws_snoop_trk.sv
module sws_snoop_trk #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_n,
  input  logic              snp_hit,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              wb_end,
  output logic              pend,
  output logic [LINE_W-1:0] line_q
);
  logic take;
  assign take = !pend && !snp_n && snp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      line_q <= '0;
    end else begin
      if (wb_end)    pend <= 1'b0;
      else if (take) pend <= 1'b1;
      if (take) line_q <= snp_line;
    end
  end
endmodule

// File: rtl/sws_fill_trk.sv
module sws_fill_trk #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [LINE_W-1:0] req_line,
  input  logic              rd_end,
  output logic              pend,
  output logic [LINE_W-1:0] line_q
);
  logic take;
  assign take = req && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      line_q <= '0;
    end else begin
      if (rd_end)    pend <= 1'b0;
      else if (take) pend <= 1'b1;
      if (take) line_q <= req_line;
    end
  end
endmodule

// File: rtl/sws_wb_seq.sv
module sws_wb_seq
  import sws_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int BEATS  = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_req,
  input  logic [LINE_W-1:0] fill_line,
  output logic              fill_done,
  input  logic              snoop_strobe_n,
  input  logic              snoop_hit_mod,
  input  logic [LINE_W-1:0] snoop_line,
  input  logic              backoff_n,
  input  logic              ready_n,
  output logic              addr_strobe_n,
  output logic              write_nread,
  output logic              last_xfer_n,
  output logic              hit_mod_n,
  output logic [LINE_W-1:0] bus_line,
  output logic [BEAT_W-1:0] bus_beat
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  seq_state_t        state, nxt;
  logic              wb_pend, fl_pend;
  logic [LINE_W-1:0] wb_line_q, fl_line_q;
  logic              in_data, rd_end, wb_end;
  logic              ctr_clr, at_last;
  logic [BEAT_W-1:0] beat_nxt;
  logic              nxt_addr, nxt_wr, nxt_rd, nxt_data;

  assign in_data = (state == ST_RDAT) || (state == ST_WDAT);
  assign rd_end  = (state == ST_RDAT) && !ready_n && at_last && backoff_n;
  assign wb_end  = (state == ST_WDAT) && !ready_n && at_last && backoff_n;
  assign ctr_clr = !backoff_n || !in_data || rd_end || wb_end;

  sws_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .clr    (ctr_clr),
    .inc    (!ready_n),
    .cnt    (bus_beat),
    .cnt_nxt(beat_nxt),
    .at_last(at_last)
  );

  sws_snoop_trk #(.LINE_W(LINE_W)) u_snp (
    .clk     (clk),
    .rst     (rst),
    .snp_n   (snoop_strobe_n),
    .snp_hit (snoop_hit_mod),
    .snp_line(snoop_line),
    .wb_end  (wb_end),
    .pend    (wb_pend),
    .line_q  (wb_line_q)
  );

  sws_fill_trk #(.LINE_W(LINE_W)) u_fill (
    .clk     (clk),
    .rst     (rst),
    .req     (fill_req),
    .req_line(fill_line),
    .rd_end  (rd_end),
    .pend    (fl_pend),
    .line_q  (fl_line_q)
  );

  // Next-state selection: write-back always ahead of the read.
  always_comb begin
    nxt = state;
    if (!backoff_n) begin
      nxt = ST_HOLD;
    end else begin
      case (state)
        ST_IDLE, ST_HOLD: begin
          if (wb_pend)      nxt = ST_WADR;
          else if (fl_pend) nxt = ST_RADR;
          else              nxt = ST_IDLE;
        end
        ST_RADR: nxt = ST_RDAT;
        ST_WADR: nxt = ST_WDAT;
        ST_RDAT: if (rd_end) nxt = wb_pend ? ST_WADR : ST_IDLE;
        ST_WDAT: if (wb_end) nxt = fl_pend ? ST_RADR : ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign nxt_addr = (nxt == ST_RADR) || (nxt == ST_WADR);
  assign nxt_wr   = (nxt == ST_WADR) || (nxt == ST_WDAT);
  assign nxt_rd   = (nxt == ST_RADR) || (nxt == ST_RDAT);
  assign nxt_data = (nxt == ST_RDAT) || (nxt == ST_WDAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      addr_strobe_n <= 1'b1;
      write_nread   <= 1'b0;
      last_xfer_n   <= 1'b1;
      fill_done     <= 1'b0;
      bus_line      <= '0;
    end else begin
      state         <= nxt;
      addr_strobe_n <= !nxt_addr;
      write_nread   <= nxt_wr;
      last_xfer_n   <= !(nxt_data && (beat_nxt == LAST_BEAT));
      fill_done     <= rd_end;
      if (nxt_wr)      bus_line <= wb_line_q;
      else if (nxt_rd) bus_line <= fl_line_q;
    end
  end

  assign hit_mod_n = !wb_pend;
endmodule

// File: rtl/sws_wb_seq_chk.sv
module sws_wb_seq_chk (
  input logic clk,
  input logic rst,
  input logic snoop_strobe_n,
  input logic snoop_hit_mod,
  input logic backoff_n,
  input logic ready_n,
  input logic addr_strobe_n,
  input logic write_nread,
  input logic last_xfer_n,
  input logic hit_mod_n
);
  // R2
  hit_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hit_mod_n) |-> $past(!snoop_strobe_n && snoop_hit_mod));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_strobe_n |=> addr_strobe_n);

  // R4
  last_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    !last_xfer_n |-> addr_strobe_n);

  // R5
  backoff_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !backoff_n |=> addr_strobe_n);

  // R6
  write_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!addr_strobe_n && write_nread) |-> !hit_mod_n);

  // R7
  hit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_mod_n) |-> $past(!ready_n && !last_xfer_n && write_nread && backoff_n));
endmodule

bind sws_wb_seq sws_wb_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .snoop_strobe_n(snoop_strobe_n),
  .snoop_hit_mod (snoop_hit_mod),
  .backoff_n     (backoff_n),
  .ready_n       (ready_n),
  .addr_strobe_n (addr_strobe_n),
  .write_nread   (write_nread),
  .last_xfer_n   (last_xfer_n),
  .hit_mod_n     (hit_mod_n)
);

// File: tb/test_sws_wb_seq.sv
module test_sws_wb_seq;
  localparam int LW    = 26;
  localparam int BEATS = 4;
  localparam int BW    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fill_req = 1'b0;
  logic [LW-1:0] fill_line = '0;
  logic          fill_done;
  logic          snoop_strobe_n = 1'b1;
  logic          snoop_hit_mod = 1'b0;
  logic [LW-1:0] snoop_line = '0;
  logic          backoff_n = 1'b1;
  logic          ready_n = 1'b1;
  logic          addr_strobe_n, write_nread, last_xfer_n, hit_mod_n;
  logic [LW-1:0] bus_line;
  logic [BW-1:0] bus_beat;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sws_wb_seq #(.LINE_W(LW), .BEATS(BEATS)) i_sws_wb_seq (
    .clk(clk), .rst(rst), .fill_req(fill_req), .fill_line(fill_line),
    .fill_done(fill_done), .snoop_strobe_n(snoop_strobe_n),
    .snoop_hit_mod(snoop_hit_mod), .snoop_line(snoop_line),
    .backoff_n(backoff_n), .ready_n(ready_n), .addr_strobe_n(addr_strobe_n),
    .write_nread(write_nread), .last_xfer_n(last_xfer_n), .hit_mod_n(hit_mod_n),
    .bus_line(bus_line), .bus_beat(bus_beat)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic start_fill(input logic [LW-1:0] ln);
    fill_req = 1'b1; fill_line = ln;
    tick();
    fill_req = 1'b0;
    tick();
  endtask

  task automatic data_beats(input int w, input bit wr, input string req);
    for (int i = 0; i < BEATS; i++) begin
      for (int k = 0; k < w; k++) begin
        ready_n = 1'b1; tick();
        chk(req, "beat hold on wait", 32'(bus_beat), 32'(i));
      end
      chk("R4", "last marker", 32'(last_xfer_n), (i == BEATS-1) ? 32'd0 : 32'd1);
      chk(req, "beat index", 32'(bus_beat), 32'(i));
      chk(req, "direction", 32'(write_nread), 32'(wr));
      ready_n = 1'b0; tick();
      ready_n = 1'b1;
    end
  endtask

  // Write-back burst from its strobe cycle, optional back-off at beat reab.
  task automatic wb_burst(input int w, input int reab, input logic [LW-1:0] sl);
    int i;
    bit done_re;
    i = 0; done_re = 0;
    ready_n = 1'b1; tick();
    while (i < BEATS) begin
      if (reab == i && !done_re) begin
        done_re = 1;
        backoff_n = 1'b0; tick();
        chk("R8", "no strobe under back-off", 32'(addr_strobe_n), 32'd1);
        backoff_n = 1'b1; tick();
        chk("R8", "write strobe again", 32'(addr_strobe_n), 32'd0);
        chk("R8", "write dir", 32'(write_nread), 32'd1);
        chk("R8", "restart beat", 32'(bus_beat), 32'd0);
        chk("R8", "line", 32'(bus_line), 32'(sl));
        tick();
        i = 0;
      end else begin
        for (int k = 0; k < w; k++) begin
          tick();
          chk("R8", "beat hold on wait", 32'(bus_beat), 32'(i));
        end
        chk("R4", "last marker wb", 32'(last_xfer_n), (i == BEATS-1) ? 32'd0 : 32'd1);
        chk("R8", "wb beat", 32'(bus_beat), 32'(i));
        ready_n = 1'b0; tick();
        ready_n = 1'b1;
        i++;
      end
    end
  endtask

  task automatic snoop_pulse(input bit hit, input logic [LW-1:0] sl);
    snoop_strobe_n = 1'b0; snoop_hit_mod = hit; snoop_line = sl;
    tick();
    snoop_strobe_n = 1'b1; snoop_hit_mod = 1'b0;
  endtask

  task automatic scen(input int a, input int l, input int w, input int reab,
                      input logic [LW-1:0] fl, input logic [LW-1:0] sl);
    start_fill(fl);
    chk("R3", "read strobe", 32'(addr_strobe_n), 32'd0);
    chk("R3", "read dir", 32'(write_nread), 32'd0);
    chk("R3", "read line", 32'(bus_line), 32'(fl));
    snoop_pulse(1'b1, sl);
    chk("R2", "hit flagged", 32'(hit_mod_n), 32'd0);
    for (int k = 0; k < a; k++) begin
      ready_n = 1'b0; tick();
      chk("R3", "beat advance", 32'(bus_beat), 32'(k + 1));
    end
    ready_n = 1'b1;
    backoff_n = 1'b0;
    for (int j = 0; j < l; j++) begin
      tick();
      chk("R5", "quiet under back-off", 32'(addr_strobe_n), 32'd1);
      chk("R5", "hit held", 32'(hit_mod_n), 32'd0);
    end
    backoff_n = 1'b1; tick();
    chk("R6", "write strobe", 32'(addr_strobe_n), 32'd0);
    chk("R6", "write dir", 32'(write_nread), 32'd1);
    chk("R6", "wb line", 32'(bus_line), 32'(sl));
    chk("R6", "wb beat 0", 32'(bus_beat), 32'd0);
    wb_burst(w, reab, sl);
    chk("R7", "replay strobe", 32'(addr_strobe_n), 32'd0);
    chk("R7", "replay dir", 32'(write_nread), 32'd0);
    chk("R7", "replay line", 32'(bus_line), 32'(fl));
    chk("R7", "replay beat 0", 32'(bus_beat), 32'd0);
    chk("R7", "hit cleared", 32'(hit_mod_n), 32'd1);
    tick();
    data_beats(w, 1'b0, "R3");
    chk("R3", "fill done", 32'(fill_done), 32'd1);
    tick();
    chk("R3", "fill done pulse", 32'(fill_done), 32'd0);
    chk("R3", "idle", 32'(addr_strobe_n), 32'd1);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1", "strobe", 32'(addr_strobe_n), 32'd1);
    chk("R1", "last", 32'(last_xfer_n), 32'd1);
    chk("R1", "hit", 32'(hit_mod_n), 32'd1);
    chk("R1", "dir", 32'(write_nread), 32'd0);
    chk("R1", "done", 32'(fill_done), 32'd0);
    chk("R1", "beat", 32'(bus_beat), 32'd0);
    rst = 1'b0;
    tick();
    chk("R1", "strobe after reset", 32'(addr_strobe_n), 32'd1);

    // Snoop without modified hit is ignored.
    snoop_pulse(1'b0, 26'h0AB);
    for (int k = 0; k < 3; k++) begin
      chk("R2", "no hit flag", 32'(hit_mod_n), 32'd1);
      chk("R2", "no cycle", 32'(addr_strobe_n), 32'd1);
      tick();
    end

    // Idle snoop: write-back two cycles after the snoop.
    snoop_pulse(1'b1, 26'h0C3);
    chk("R2", "hit flagged idle", 32'(hit_mod_n), 32'd0);
    chk("R9", "not yet", 32'(addr_strobe_n), 32'd1);
    tick();
    chk("R9", "idle wb strobe", 32'(addr_strobe_n), 32'd0);
    chk("R9", "idle wb dir", 32'(write_nread), 32'd1);
    chk("R9", "idle wb line", 32'(bus_line), 32'h0C3);
    wb_burst(0, -1, 26'h0C3);
    chk("R9", "idle after wb", 32'(addr_strobe_n), 32'd1);
    chk("R9", "hit cleared", 32'(hit_mod_n), 32'd1);
    tick();

    // Snoop during fill, no back-off: fill first, then write-back.
    start_fill(26'h111);
    snoop_pulse(1'b1, 26'h222);
    data_beats(1, 1'b0, "R3");
    chk("R9", "fill done", 32'(fill_done), 32'd1);
    chk("R9", "wb strobe with done", 32'(addr_strobe_n), 32'd0);
    chk("R9", "wb dir", 32'(write_nread), 32'd1);
    chk("R9", "wb line", 32'(bus_line), 32'h222);
    wb_burst(0, -1, 26'h222);
    chk("R9", "idle", 32'(addr_strobe_n), 32'd1);
    tick();

    // Back-off without snoop: read reissued.
    start_fill(26'h333);
    ready_n = 1'b1; tick();
    ready_n = 1'b0; tick();
    ready_n = 1'b1; backoff_n = 1'b0;
    tick();
    chk("R5", "quiet", 32'(addr_strobe_n), 32'd1);
    tick();
    backoff_n = 1'b1; tick();
    chk("R10", "read reissue", 32'(addr_strobe_n), 32'd0);
    chk("R10", "read dir", 32'(write_nread), 32'd0);
    chk("R10", "line", 32'(bus_line), 32'h333);
    chk("R10", "beat 0", 32'(bus_beat), 32'd0);
    tick();
    data_beats(0, 1'b0, "R10");
    chk("R10", "fill done", 32'(fill_done), 32'd1);
    tick();

    // Sweep: abort beat, back-off length, wait states, second back-off point.
    for (int a = 0; a < BEATS; a++)
      for (int l = 1; l <= 3; l++)
        for (int w = 0; w <= 1; w++)
          for (int r = -1; r < BEATS; r++)
            scen(a, l, w, r, LW'(26'h1000 + a*64 + l*16 + w*8 + r + 1),
                 LW'(26'h2000 + a*64 + l*16 + w*8 + r + 1));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule